// File: doc/BRIEF.md
# Transmit Byte Queue with Watermark

This block is the transmit-side byte queue of a register-mapped serial port. Each write strobe to the transmit data register stores the least significant byte of the written word at the tail of the queue. The head entry is presented to a serial shifter on a valid/ready handshake. Bytes leave only while the transmit enable is set.

The block reports a full flag, an empty flag and a level readout for a status register. It also emits one-cycle event pulses that an interrupt bank latches:
- a watermark-reached event;
- a watermark-cleared event;
- a queue-drained event.

The watermark threshold comes from a 3-bit select field. A flush strobe, driven from the reset bit of the FIFO control register, discards the queue contents at once.

Top module: `uart_txq`

## Requirements
- R1: After reset the queue is empty: `empty_o`=1, `full_o`=0, `level_o`=0, `out_valid_o`=0, and no event pulse is asserted.
- R2: A data write stores bits [7:0] of `wdata_i`. Bytes reach `out_data_o` in the order they were written. `out_data_o` shows the head entry whenever `out_valid_o` is 1.
- R3: A data write while the queue holds DEPTH (32) bytes is dropped. The level and the stored bytes are unchanged.
- R4: `full_o` is 1 exactly when the level equals DEPTH.
- R5: `empty_o` is 1 exactly when the level is zero. `empty_evt_o` pulses for one cycle, together with the new level, on every cycle in which a non-zero level becomes zero.
- R6: `wm_set_o` pulses for one cycle, together with the new level, when a write is accepted and the resulting level is at or above the threshold. Threshold select codes map as follows: 0→1, 1→4, 2→8, 3→16, 4 to 7→30.
- R7: `wm_clr_o` pulses for one cycle, together with the new level, when the level moves from at or above the threshold to below it.
- R8: `flush_i` empties the queue in the next cycle. It takes priority over a simultaneous write or read, and a write in that cycle is discarded.
- R9: `level_o` is the level saturated to 5 bits: min(level, 31).
- R10: `out_valid_o` is 1 only while `tx_en_i` is 1 and the queue is non-empty. No byte is removed while `tx_en_i` is 0.
- R11: An accepted write and a completed read in the same cycle leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe for the transmit data register |
| wdata_i | input | 32 | Written word; only bits [7:0] are stored |
| flush_i | input | 1 | Queue reset strobe |
| thr_sel_i | input | 3 | Watermark threshold select |
| tx_en_i | input | 1 | Transmit enable |
| out_data_o | output | 8 | Head byte toward the shifter |
| out_valid_o | output | 1 | Head byte available |
| out_ready_i | input | 1 | Shifter accepts the head byte |
| full_o | output | 1 | Queue full status |
| empty_o | output | 1 | Queue empty status |
| level_o | output | 5 | Saturated level readout |
| wm_set_o | output | 1 | Watermark-reached event pulse |
| wm_clr_o | output | 1 | Watermark-cleared event pulse |
| empty_evt_o | output | 1 | Queue-drained event pulse |

## Verification
The bench builds the block with its default depth of 32, 32-bit words and a 5-bit readout. At this size every level from 0 to 32 is reachable within a few dozen cycles. For each of the eight threshold codes the bench fills the queue past full and then drains it, which exercises every threshold crossing, the saturated readout at 32, and the dropped write at full. Further passes cover simultaneous write and read at several levels, flush at mid and full level with competing traffic, and a stalling ready pattern. The expected values come from a byte-queue model in the bench.

// File: rtl/uart_txq.sv
module uart_txq #(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int RD_W   = 5,
  parameter int THR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              flush_i,
  input  logic [THR_W-1:0]  thr_sel_i,
  input  logic              tx_en_i,
  output logic [BYTE_W-1:0] out_data_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              full_o,
  output logic              empty_o,
  output logic [RD_W-1:0]   level_o,
  output logic              wm_set_o,
  output logic              wm_clr_o,
  output logic              empty_evt_o
);
  localparam int PTR_W   = $clog2(DEPTH);
  localparam int LVL_W   = $clog2(DEPTH + 1);
  localparam int RD_MAX  = (1 << RD_W) - 1;
  localparam int TOP_THR = (DEPTH < 30) ? DEPTH : 30;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [LVL_W-1:0]  level, level_nxt, thr;
  logic              push_ok, pop_ok;
  logic              unused_hi;

  assign unused_hi = ^wdata_i[WORD_W-1:BYTE_W];

  always_comb begin
    case (thr_sel_i)
      3'd0:    thr = LVL_W'(1);
      3'd1:    thr = LVL_W'(4);
      3'd2:    thr = LVL_W'(8);
      3'd3:    thr = LVL_W'(16);
      default: thr = LVL_W'(TOP_THR);
    endcase
  end

  assign full_o      = (level == LVL_W'(DEPTH));
  assign empty_o     = (level == '0);
  assign out_valid_o = tx_en_i && !empty_o;
  assign out_data_o  = mem[rd_ptr];
  assign level_o     = (level > LVL_W'(RD_MAX)) ? RD_W'(RD_MAX) : RD_W'(level);

  assign push_ok = wr_i && !full_o && !flush_i;
  assign pop_ok  = out_valid_o && out_ready_i && !flush_i;

  always_comb begin
    if (flush_i)              level_nxt = '0;
    else if (push_ok && !pop_ok) level_nxt = level + 1'b1;
    else if (pop_ok && !push_ok) level_nxt = level - 1'b1;
    else                      level_nxt = level;
  end

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata_i[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr      <= '0;
      rd_ptr      <= '0;
      level       <= '0;
      wm_set_o    <= 1'b0;
      wm_clr_o    <= 1'b0;
      empty_evt_o <= 1'b0;
    end else begin
      if (flush_i) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push_ok) wr_ptr <= bump(wr_ptr);
        if (pop_ok)  rd_ptr <= bump(rd_ptr);
      end
      level       <= level_nxt;
      wm_set_o    <= push_ok && (level_nxt >= thr);
      wm_clr_o    <= (level >= thr) && (level_nxt < thr);
      empty_evt_o <= (level != '0) && (level_nxt == '0);
    end
  end

  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));
  a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && wr_i && !out_ready_i && !flush_i) |=> full_o);
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> empty_o);
  a_r10_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_i |-> !out_valid_o);
  a_r11_pushpop_level: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !full_o && out_valid_o && out_ready_i && !flush_i) |=> level_o == $past(level_o));
  a_r5_drain_event: assert property (@(posedge clk) disable iff (!rst_n)
    empty_evt_o |-> empty_o);
  a_r6_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wm_set_o && wm_clr_o));
endmodule

// File: tb/sim_uart_txq.sv
module sim_uart_txq;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        flush_i = 1'b0;
  logic [2:0]  thr_sel_i = '0;
  logic        tx_en_i = 1'b0;
  logic        out_ready_i = 1'b0;
  logic [7:0]  out_data_o;
  logic        out_valid_o, full_o, empty_o, wm_set_o, wm_clr_o, empty_evt_o;
  logic [4:0]  level_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  byte unsigned q[$];
  int  seed_byte = 7;

  always #4 clk = ~clk;

  uart_txq u0 (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .wdata_i(wdata_i), .flush_i(flush_i),
    .thr_sel_i(thr_sel_i), .tx_en_i(tx_en_i), .out_data_o(out_data_o),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .full_o(full_o),
    .empty_o(empty_o), .level_o(level_o), .wm_set_o(wm_set_o), .wm_clr_o(wm_clr_o),
    .empty_evt_o(empty_evt_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int thr_of(input int code);
    case (code)
      0: return 1;
      1: return 4;
      2: return 8;
      3: return 16;
      default: return 30;
    endcase
  endfunction

  task automatic step(input bit wr, input bit fl, input int code, input bit en, input bit rdy);
    int ol, nl, th;
    bit pop, push;
    @(negedge clk);
    seed_byte = (seed_byte * 37 + 11) % 256;
    wr_i = wr; flush_i = fl; thr_sel_i = 3'(code); tx_en_i = en; out_ready_i = rdy;
    wdata_i = {24'h5A3C96 ^ 24'(seed_byte * 4099), 8'(seed_byte)};
    #1;
    ol = q.size();
    chk(out_valid_o == (en && ol > 0), "R10 out_valid", out_valid_o, en && ol > 0);
    if (en && ol > 0) chk(out_data_o == q[0], "R2 head byte", out_data_o, q[0]);
    pop  = en && rdy && ol > 0;
    push = wr && ol < DEPTH;
    if (fl) q.delete();
    else begin
      if (pop)  void'(q.pop_front());
      if (push) q.push_back(byte'(seed_byte));
    end
    nl = q.size();
    th = thr_of(code);
    @(posedge clk); #1;
    chk(level_o == ((nl > 31) ? 31 : nl), "R9 level readout", level_o, (nl > 31) ? 31 : nl);
    chk(full_o == (nl == DEPTH), "R4 full", full_o, nl == DEPTH);
    chk(empty_o == (nl == 0), "R5 empty", empty_o, nl == 0);
    chk(empty_evt_o == (ol != 0 && nl == 0), "R5 empty event", empty_evt_o, ol != 0 && nl == 0);
    chk(wm_set_o == (!fl && push && nl >= th), "R6 watermark set", wm_set_o, !fl && push && nl >= th);
    chk(wm_clr_o == (ol >= th && nl < th), "R7 watermark clear", wm_clr_o, ol >= th && nl < th);
    if (wr && !fl && ol == DEPTH && !pop) chk(nl == DEPTH, "R3 dropped at full", nl, DEPTH);
    if (push && pop && !fl) chk(level_o == ((ol > 31) ? 31 : ol), "R11 push+pop level", level_o, ol);
    if (fl) chk(empty_o == 1'b1, "R8 flush", empty_o, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(empty_o == 1 && full_o == 0, "R1 reset flags", {full_o, empty_o}, 1);
    chk(level_o == 0 && !out_valid_o, "R1 reset level/valid", level_o, 0);
    chk(!wm_set_o && !wm_clr_o && !empty_evt_o, "R1 reset events", {wm_set_o, wm_clr_o, empty_evt_o}, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int code = 0; code < 8; code++) begin
      step(0, 1, code, 0, 0);
      for (int i = 0; i < DEPTH + 3; i++) step(1, 0, code, 0, 1);  // R3 fill past full
      for (int i = 0; i < DEPTH + 2; i++) step(0, 0, code, 1, 1);  // R2 R5 R7 drain
    end

    for (int lv = 1; lv <= DEPTH; lv += 5) begin                   // R11 at several levels
      step(0, 1, 2, 0, 0);
      for (int i = 0; i < lv; i++) step(1, 0, 2, 0, 0);
      for (int i = 0; i < 4; i++) step(1, 0, 2, 1, 1);
    end

    for (int i = 0; i < 10; i++) step(1, 0, 1, 0, 0);              // R8 flush mid-level with traffic
    step(1, 1, 1, 1, 1);
    for (int i = 0; i < DEPTH; i++) step(1, 0, 4, 0, 0);
    step(1, 1, 4, 1, 1);                                            // R8 flush at full

    for (int i = 0; i < 120; i++)                                   // R10 stalls and enable gaps
      step((i % 3) != 2, 0, i % 8, (i % 7) != 0, (i % 4) != 1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule